// File: doc/BRIEF.md
# Bank-Group-Aware DRAM Request Scheduler

This block sits between an address decoder and a DRAM command generator. It keeps a small queue of pending memory reads and writes, each already split into direction, bank group, bank, row and column, and on each cycle it offers one of them on a valid/ready output. It also offers a flag that tells whether that request targets a row that is already open in its bank.

The pick order combines three aims. Reads and writes are served in runs of one direction so the data bus turns around less often. Within a run, requests to an already open row go first. After that, a request whose bank group differs from the last issued one is preferred, because column commands across groups may be spaced more tightly. An oldest-first rule breaks any remaining tie. Two limits stop starvation. A run of one direction ends after a set number of issues. A request of the other direction that has waited too long also ends the run. Requests to the same full address keep their arrival order. The open-row table is updated when a request leaves the block.

Top module: `ddr_bg_sched`

## Requirements
- R1: The queue holds up to DEPTH (8) requests. `in_ready_o` is low exactly when 8 requests are pending. Every accepted request leaves once, with its fields unchanged.
- R2: `out_hit_o` is 1 exactly when the offered request's bank (bank group and bank) has an open row equal to the request's row.
- R3: Within the chosen direction, a request that hits an open row is offered before any miss, even if the miss is older or in a better bank group.
- R4: Among requests equal under R3, one whose bank group differs from the last issued request's bank group is preferred. Before any issue after reset, every bank group counts as differing.
- R5: Among requests equal under R3 and R4, the oldest is offered.
- R6: Direction encoding is `in_write_i`/`out_write_o` = 0 for read and 1 for write. After reset the current direction is read. The block keeps to the current direction while an eligible request of it is pending, and switches when none remains.
- R7: After BATCH_MAX (16) consecutive issues in one direction, the direction switches if a request of the other direction is eligible.
- R8: A request of the other direction that has been pending for more than AGE_LIMIT (32) cycles forces a switch at the next issue.
- R9: Of two requests with equal bank group, bank, row and column, the later one is not offered until the earlier one has left, whatever their directions.
- R10: When a request leaves (valid and ready both high), the open-row entry of its bank becomes its row. A later request to that bank and row then reports a hit.
- R11: Reset (active-low, asynchronous) empties the queue and marks every bank as having no open row.
- R12: `out_valid_o` is high exactly when at least one request is pending, and it stays high while the output is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | New request present |
| in_ready_o | output | 1 | Queue can accept a request |
| in_write_i | input | 1 | 1 = write, 0 = read |
| in_bg_i | input | BG_W | Bank group |
| in_ba_i | input | BA_W | Bank within group |
| in_row_i | input | ROW_W | Row |
| in_col_i | input | COL_W | Column |
| out_valid_o | output | 1 | A request is offered |
| out_ready_i | input | 1 | Downstream takes the offered request |
| out_write_o | output | 1 | Direction of offered request |
| out_bg_o | output | BG_W | Bank group of offered request |
| out_ba_o | output | BA_W | Bank of offered request |
| out_row_o | output | ROW_W | Row of offered request |
| out_col_o | output | COL_W | Column of offered request |
| out_hit_o | output | 1 | Offered request hits the open row of its bank |

## Verification
A stale or corrupt open-row entry shows on the next request to that bank as a wrong `out_hit_o`, in the same cycle the request is offered. It also shows as a changed issue order whenever a hit competes with a miss. A wrong arrival-order matrix or age count does not show while the queue holds one request. It shows only when two candidates tie, when same-address requests meet, or after the age window ends, so the directed cases build exactly those contests. A wrong occupancy count shows at once as a ready or valid flag that disagrees with the number of requests taken in minus those sent out.

// File: rtl/ddr_sched_pkg.sv
package ddr_sched_pkg;

  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } dir_e;

  function automatic dir_e flip_dir(input dir_e d);
    return (d == DIR_RD) ? DIR_WR : DIR_RD;
  endfunction

endpackage

// File: rtl/sched_bank_table.sv
module sched_bank_table #(
  parameter int unsigned BG_W  = 2,
  parameter int unsigned BA_W  = 2,
  parameter int unsigned ROW_W = 8
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               upd_i,
  input  logic [BG_W+BA_W-1:0]               upd_bank_i,
  input  logic [ROW_W-1:0]                   upd_row_i,
  output logic [(1<<(BG_W+BA_W))-1:0]        open_o,
  output logic [(1<<(BG_W+BA_W))-1:0][ROW_W-1:0] row_o
);
  localparam int unsigned NBANK = 1 << (BG_W + BA_W);

  logic [NBANK-1:0]            open_q;
  logic [NBANK-1:0][ROW_W-1:0] row_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q[b] <= 1'b0;
        row_q[b]  <= '0;
      end else if (upd_i && upd_bank_i == (BG_W+BA_W)'(b)) begin
        open_q[b] <= 1'b1;
        row_q[b]  <= upd_row_i;
      end
    end
  end

  assign open_o = open_q;
  assign row_o  = row_q;
endmodule

// File: rtl/sched_queue.sv
module sched_queue #(
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned DW        = 19,
  parameter int unsigned AGE_LIMIT = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           push_i,
  input  logic [DW-1:0]                  push_data_i,
  input  logic                           pop_i,
  input  logic [$clog2(DEPTH)-1:0]       pop_idx_i,
  output logic                           full_o,
  output logic [DEPTH-1:0]               valid_o,
  output logic [DEPTH-1:0][DW-1:0]       data_o,
  output logic [DEPTH-1:0][DEPTH-1:0]    older_o,
  output logic [DEPTH-1:0]               starved_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned AGE_W = $clog2(AGE_LIMIT + 2);
  localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(AGE_LIMIT + 1);

  logic [DEPTH-1:0]             vld_q;
  logic [DEPTH-1:0][DW-1:0]     data_q;
  logic [DEPTH-1:0][AGE_W-1:0]  age_q;
  logic [DEPTH-1:0][DEPTH-1:0]  older_q;  // row i, bit j: entry j arrived before entry i
  logic [IDX_W-1:0]             free_idx;
  logic                         full;
  logic [DEPTH-1:0]             set_vec, clr_vec;

  always_comb begin
    free_idx = '0;
    full     = 1'b1;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        free_idx = IDX_W'(i);
        full     = 1'b0;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      set_vec[i] = push_i && !full && (free_idx == IDX_W'(i));
      clr_vec[i] = pop_i && (pop_idx_i == IDX_W'(i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= '0;
      age_q   <= '0;
      older_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (set_vec[i]) begin
          vld_q[i]   <= 1'b1;
          age_q[i]   <= '0;
          older_q[i] <= vld_q & ~clr_vec;
        end else begin
          older_q[i] <= older_q[i] & ~set_vec;  // a reused slot is never older
          if (clr_vec[i]) vld_q[i] <= 1'b0;
          else if (vld_q[i] && age_q[i] != AGE_SAT) age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (set_vec[i]) data_q[i] <= push_data_i;
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) starved_o[i] = vld_q[i] && (age_q[i] > AGE_W'(AGE_LIMIT));
  end

  assign full_o  = full;
  assign valid_o = vld_q;
  assign data_o  = data_q;
  assign older_o = older_q;
endmodule

// File: rtl/sched_picker.sv
module sched_picker
  import ddr_sched_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned BG_W  = 2,
  parameter int unsigned BA_W  = 2,
  parameter int unsigned ROW_W = 8,
  parameter int unsigned COL_W = 6
) (
  input  logic [DEPTH-1:0]                               valid_i,
  input  logic [DEPTH-1:0][COL_W+ROW_W+BA_W+BG_W:0]      data_i,
  input  logic [DEPTH-1:0][DEPTH-1:0]                    older_i,
  input  logic [DEPTH-1:0]                               starved_i,
  input  logic [(1<<(BG_W+BA_W))-1:0]                    open_i,
  input  logic [(1<<(BG_W+BA_W))-1:0][ROW_W-1:0]         open_row_i,
  input  dir_e                                           cur_dir_i,
  input  logic                                           batch_done_i,
  input  logic [BG_W-1:0]                                last_bg_i,
  input  logic                                           last_vld_i,
  output logic                                           sel_vld_o,
  output logic [$clog2(DEPTH)-1:0]                       sel_idx_o,
  output dir_e                                           sel_dir_o,
  output logic                                           sel_hit_o
);
  localparam int unsigned IDX_W   = $clog2(DEPTH);
  localparam int unsigned BK_W    = BG_W + BA_W;
  localparam int unsigned ROW_LSB = COL_W;
  localparam int unsigned BA_LSB  = COL_W + ROW_W;
  localparam int unsigned BG_LSB  = BA_LSB + BA_W;
  localparam int unsigned WE_BIT  = BG_LSB + BG_W;

  logic [DEPTH-1:0]            we_v, hit_v, bgd_v, elig_v;
  logic [DEPTH-1:0][DEPTH-1:0] same_v;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [BK_W-1:0] bidx;
    assign bidx     = data_i[g][BA_LSB +: BK_W];
    assign we_v[g]  = data_i[g][WE_BIT];
    assign hit_v[g] = open_i[bidx] && (open_row_i[bidx] == data_i[g][ROW_LSB +: ROW_W]);
    assign bgd_v[g] = !last_vld_i || (data_i[g][BG_LSB +: BG_W] != last_bg_i);
    for (genvar j = 0; j < DEPTH; j++) begin : g_cmp
      assign same_v[g][j] = (data_i[g][WE_BIT-1:0] == data_i[j][WE_BIT-1:0]);
    end
    // an older request to the same address blocks this one
    assign elig_v[g] = valid_i[g] && !(|(older_i[g] & same_v[g] & valid_i));
  end

  logic [DEPTH-1:0] rd_e, wr_e, cur_e, oth_e, cand, t_hb, t_h, t_b, pick;
  logic             swap;

  always_comb begin
    rd_e  = elig_v & ~we_v;
    wr_e  = elig_v & we_v;
    cur_e = (cur_dir_i == DIR_WR) ? wr_e : rd_e;
    oth_e = (cur_dir_i == DIR_WR) ? rd_e : wr_e;
    swap  = (|oth_e) && (!(|cur_e) || batch_done_i || (|(oth_e & starved_i)));
    cand  = swap ? oth_e : cur_e;
    t_hb  = cand & hit_v & bgd_v;
    t_h   = cand & hit_v;
    t_b   = cand & bgd_v;
    if (|t_hb)      pick = t_hb;
    else if (|t_h)  pick = t_h;
    else if (|t_b)  pick = t_b;
    else            pick = cand;

    sel_idx_o = '0;
    sel_hit_o = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (pick[i] && !(|(older_i[i] & pick))) begin
        sel_idx_o = IDX_W'(i);
        sel_hit_o = hit_v[i];
      end
    end
    sel_vld_o = |pick;
    sel_dir_o = swap ? flip_dir(cur_dir_i) : cur_dir_i;
  end
endmodule

// File: rtl/ddr_bg_sched.sv
module ddr_bg_sched
  import ddr_sched_pkg::*;
#(
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned BG_W      = 2,
  parameter int unsigned BA_W      = 2,
  parameter int unsigned ROW_W     = 8,
  parameter int unsigned COL_W     = 6,
  parameter int unsigned BATCH_MAX = 16,
  parameter int unsigned AGE_LIMIT = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic             in_write_i,
  input  logic [BG_W-1:0]  in_bg_i,
  input  logic [BA_W-1:0]  in_ba_i,
  input  logic [ROW_W-1:0] in_row_i,
  input  logic [COL_W-1:0] in_col_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic             out_write_o,
  output logic [BG_W-1:0]  out_bg_o,
  output logic [BA_W-1:0]  out_ba_o,
  output logic [ROW_W-1:0] out_row_o,
  output logic [COL_W-1:0] out_col_o,
  output logic             out_hit_o
);
  localparam int unsigned DW    = 1 + BG_W + BA_W + ROW_W + COL_W;
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned NBANK = 1 << (BG_W + BA_W);
  localparam int unsigned BC_W  = $clog2(BATCH_MAX + 1);

  logic                          full, fire, sel_vld, sel_hit;
  logic [IDX_W-1:0]              sel_idx;
  dir_e                          sel_dir, cur_dir_q;
  logic [DEPTH-1:0]              q_valid, q_starved;
  logic [DEPTH-1:0][DW-1:0]      q_data;
  logic [DEPTH-1:0][DEPTH-1:0]   q_older;
  logic [NBANK-1:0]              bk_open;
  logic [NBANK-1:0][ROW_W-1:0]   bk_row;
  logic [BC_W-1:0]               batch_q;
  logic [BG_W-1:0]               last_bg_q;
  logic                          last_vld_q;
  logic [DW-1:0]                 sel_data;

  sched_queue #(.DEPTH(DEPTH), .DW(DW), .AGE_LIMIT(AGE_LIMIT)) u_queue (
    .clk_i, .rst_ni,
    .push_i      (in_valid_i),
    .push_data_i ({in_write_i, in_bg_i, in_ba_i, in_row_i, in_col_i}),
    .pop_i       (fire),
    .pop_idx_i   (sel_idx),
    .full_o      (full),
    .valid_o     (q_valid),
    .data_o      (q_data),
    .older_o     (q_older),
    .starved_o   (q_starved)
  );

  sched_bank_table #(.BG_W(BG_W), .BA_W(BA_W), .ROW_W(ROW_W)) u_banks (
    .clk_i, .rst_ni,
    .upd_i      (fire),
    .upd_bank_i ({out_bg_o, out_ba_o}),
    .upd_row_i  (out_row_o),
    .open_o     (bk_open),
    .row_o      (bk_row)
  );

  sched_picker #(.DEPTH(DEPTH), .BG_W(BG_W), .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_pick (
    .valid_i      (q_valid),
    .data_i       (q_data),
    .older_i      (q_older),
    .starved_i    (q_starved),
    .open_i       (bk_open),
    .open_row_i   (bk_row),
    .cur_dir_i    (cur_dir_q),
    .batch_done_i (batch_q >= BC_W'(BATCH_MAX)),
    .last_bg_i    (last_bg_q),
    .last_vld_i   (last_vld_q),
    .sel_vld_o    (sel_vld),
    .sel_idx_o    (sel_idx),
    .sel_dir_o    (sel_dir),
    .sel_hit_o    (sel_hit)
  );

  assign sel_data    = q_data[sel_idx];
  assign in_ready_o  = !full;
  assign out_valid_o = sel_vld;
  assign out_hit_o   = sel_hit;
  assign {out_write_o, out_bg_o, out_ba_o, out_row_o, out_col_o} = sel_data;
  assign fire        = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_dir_q  <= DIR_RD;
      batch_q    <= '0;
      last_bg_q  <= '0;
      last_vld_q <= 1'b0;
    end else if (fire) begin
      cur_dir_q  <= sel_dir;
      last_bg_q  <= out_bg_o;
      last_vld_q <= 1'b1;
      if (sel_dir != cur_dir_q)            batch_q <= BC_W'(1);
      else if (batch_q != BC_W'(BATCH_MAX)) batch_q <= batch_q + 1'b1;
    end
  end
endmodule

// File: rtl/ddr_bg_sched_chk.sv
module ddr_bg_sched_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned BG_W  = 2,
  parameter int unsigned BA_W  = 2,
  parameter int unsigned ROW_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [BG_W-1:0]  out_bg_o,
  input logic [BA_W-1:0]  out_ba_o,
  input logic [ROW_W-1:0] out_row_o,
  input logic             out_hit_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             in_fire, out_fire;
  logic [CNT_W-1:0] occ_q;

  assign in_fire  = in_valid_i && in_ready_o;
  assign out_fire = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else         occ_q <= occ_q + CNT_W'(in_fire) - CNT_W'(out_fire);
  end

  p_ready_full_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o == (occ_q != CNT_W'(DEPTH)));

  p_valid_pending_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == (occ_q != '0));

  p_stall_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> out_valid_o);

  p_reopen_hit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_fire |=> (!(out_valid_o && out_bg_o == $past(out_bg_o) && out_ba_o == $past(out_ba_o)
                    && out_row_o == $past(out_row_o)) || out_hit_o));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_idle_r11: assert (!out_valid_o && in_ready_o);
    end
  end
endmodule

bind ddr_bg_sched ddr_bg_sched_chk #(
  .DEPTH(DEPTH), .BG_W(BG_W), .BA_W(BA_W), .ROW_W(ROW_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_bg_o(out_bg_o),
  .out_ba_o(out_ba_o), .out_row_o(out_row_o), .out_hit_o(out_hit_o)
);

// File: tb/ddr_bg_sched_tb.sv
module ddr_bg_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BG_W = 2, BA_W = 2, ROW_W = 8, COL_W = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic in_valid = 1'b0, in_write = 1'b0, out_ready = 1'b0;
  logic [BG_W-1:0] in_bg = '0;
  logic [BA_W-1:0] in_ba = '0;
  logic [ROW_W-1:0] in_row = '0;
  logic [COL_W-1:0] in_col = '0;
  logic in_ready_o, out_valid_o, out_write_o, out_hit_o;
  logic [BG_W-1:0] out_bg_o;
  logic [BA_W-1:0] out_ba_o;
  logic [ROW_W-1:0] out_row_o;
  logic [COL_W-1:0] out_col_o;

  int checks = 0, errors = 0, log_n = 0;
  logic lg_we [64];
  logic lg_hit [64];
  int   lg_bg [64];
  int   lg_row [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_bg_sched u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready_o),
    .in_write_i(in_write), .in_bg_i(in_bg), .in_ba_i(in_ba), .in_row_i(in_row), .in_col_i(in_col),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready), .out_write_o(out_write_o),
    .out_bg_o(out_bg_o), .out_ba_o(out_ba_o), .out_row_o(out_row_o), .out_col_o(out_col_o),
    .out_hit_o(out_hit_o)
  );

  always @(negedge clk) begin
    if (rst_ni && out_valid_o && out_ready && log_n < 64) begin
      lg_we[log_n]  = out_write_o;
      lg_hit[log_n] = out_hit_o;
      lg_bg[log_n]  = int'(out_bg_o);
      lg_row[log_n] = int'(out_row_o);
      log_n++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0; out_ready = 1'b0; rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;
    log_n = 0;
  endtask

  task automatic push(input logic we, input int bg, input int ba, input int row, input int col);
    chk("R1", "ready before push", int'(in_ready_o), 1);
    in_valid = 1'b1; in_write = we;
    in_bg = BG_W'(bg); in_ba = BA_W'(ba); in_row = ROW_W'(row); in_col = COL_W'(col);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic drain(input int n);
    out_ready = 1'b1;
    repeat (n) @(posedge clk);
    #1 out_ready = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11", "valid after reset", int'(out_valid_o), 0);
    chk("R11", "ready after reset", int'(in_ready_o), 1);
    push(1'b0, 1, 2, 5, 0);
    chk("R2", "hit on closed bank", int'(out_hit_o), 0);
    drain(2);
    push(1'b0, 1, 2, 5, 1);
    chk("R12", "valid with pending", int'(out_valid_o), 1);
    chk("R2", "hit on opened row", int'(out_hit_o), 1);
    do_reset();
    chk("R11", "queue emptied", int'(out_valid_o), 0);
    push(1'b0, 1, 2, 5, 1);
    chk("R11", "row table cleared", int'(out_hit_o), 0);
    drain(2);
  endtask

  task automatic t_full();
    logic [7:0] seen = '0;
    do_reset();
    for (int i = 0; i < 8; i++) push(1'b0, i % 4, i / 4, i, i);
    chk("R1", "ready when full", int'(in_ready_o), 0);
    chk("R12", "valid when full", int'(out_valid_o), 1);
    drain(10);
    chk("R1", "issue count", log_n, 8);
    for (int i = 0; i < log_n; i++) seen[lg_row[i] % 8] = 1'b1;
    chk("R1", "each request once", int'(seen), 255);
    chk("R12", "valid when empty", int'(out_valid_o), 0);
    chk("R1", "ready when empty", int'(in_ready_o), 1);
  endtask

  task automatic t_hit_first();
    do_reset();
    push(1'b0, 0, 0, 5, 0);
    drain(2);
    push(1'b0, 0, 0, 7, 1);  // miss, same group
    push(1'b0, 2, 0, 3, 2);  // miss, other group
    push(1'b0, 0, 0, 5, 3);  // hit, same group
    drain(5);
    chk("R3", "hit goes first row", lg_row[1], 5);
    chk("R2", "hit flag of hit", int'(lg_hit[1]), 1);
    chk("R4", "other group next row", lg_row[2], 3);
    chk("R4", "same group last row", lg_row[3], 7);
    chk("R2", "miss flag", int'(lg_hit[3]), 0);
    push(1'b0, 0, 0, 7, 4);
    chk("R10", "table holds new row", int'(out_hit_o), 1);
    drain(2);
    push(1'b0, 0, 0, 5, 5);
    chk("R10", "old row closed", int'(out_hit_o), 0);
    drain(2);
  endtask

  task automatic t_oldest();
    do_reset();
    push(1'b0, 1, 0, 1, 0);
    push(1'b0, 2, 1, 2, 0);
    push(1'b0, 3, 2, 3, 0);
    drain(4);
    chk("R5", "oldest first", lg_row[0], 1);
    chk("R5", "then next oldest", lg_row[1], 2);
    chk("R5", "then last", lg_row[2], 3);
  endtask

  task automatic t_batch();
    do_reset();
    push(1'b1, 0, 0, 1, 0);
    push(1'b0, 1, 0, 2, 0);
    push(1'b1, 2, 0, 3, 0);
    push(1'b0, 3, 0, 4, 0);
    drain(5);
    chk("R6", "first is read", lg_row[0], 2);
    chk("R6", "second is read", lg_row[1], 4);
    chk("R6", "third is write", lg_row[2], 1);
    chk("R6", "third dir", int'(lg_we[2]), 1);
    chk("R6", "fourth is write", lg_row[3], 3);
  endtask

  task automatic t_batch_limit();
    int rd_run = 0;
    do_reset();
    push(1'b1, 0, 0, 200, 0);
    for (int i = 1; i < 8; i++) push(1'b0, i % 4, (i / 4) % 4, i, 0);
    out_ready = 1'b1;
    for (int k = 0; k < 22; k++) begin
      if (in_ready_o) begin
        in_valid = 1'b1; in_write = 1'b0;
        in_bg = BG_W'(k % 4); in_ba = BA_W'((k / 4) % 4); in_row = ROW_W'(8 + k); in_col = '0;
      end else begin
        in_valid = 1'b0;
      end
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
    drain(12);
    for (int i = 0; i < 16; i++) if (!lg_we[i]) rd_run++;
    chk("R7", "reads before switch", rd_run, 16);
    chk("R7", "write after 16 reads", int'(lg_we[16]), 1);
  endtask

  task automatic t_starve();
    do_reset();
    push(1'b1, 0, 0, 1, 0);
    push(1'b0, 1, 0, 2, 0);
    push(1'b0, 2, 0, 3, 0);
    idle(40);
    drain(4);
    chk("R8", "starved write first", int'(lg_we[0]), 1);
    chk("R8", "reads follow", int'(lg_we[1]), 0);
  endtask

  task automatic t_order();
    do_reset();
    push(1'b1, 1, 1, 9, 4);
    push(1'b0, 1, 1, 9, 4);
    drain(3);
    chk("R9", "earlier write first", int'(lg_we[0]), 1);
    chk("R9", "later read second", int'(lg_we[1]), 0);
    chk("R10", "read hits row of write", int'(lg_hit[1]), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_full();
    t_hit_first();
    t_oldest();
    t_batch();
    t_batch_limit();
    t_starve();
    t_order();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule